// File: doc/BRIEF.md
# Two-Mode Multicart Bank Mapper

This block sits between a CPU with a 16-bit address bus and the ROM and external RAM of a cartridge that holds several games. After reset it runs in a flat mode. In flat mode the lowest 32 KB of the CPU space reaches the ROM without any change. Software can also pick a base bank, which marks where the chosen game begins. The first write into the lowest 8 KB region switches the mapper into a banking mode. Only reset brings it back to flat mode. In banking mode the fixed lower window and the switchable upper window both move up past two reserved banks plus the base. The upper window also adds a selectable offset bank, which is clamped so that it never runs beyond the last ROM bank.

Control writes share the ROM address ranges. The mode in force decides what each of these writes means. Access to external RAM in the 0xA000-0xBFFF window is gated by an enable bit and goes through a selectable 8 KB RAM bank. A CPU read registers the physical address one clock later. The read data is then taken from the memory the access was routed to, or is 0xFF when the mapper serves nothing at that address.

Top module: `mmc_multicart_mapper`

## Requirements
- R1: After reset the mapper is in flat mode with base bank 0, offset bank 1, RAM bank 0 and RAM disabled, and cpu_rdata reads 0xFF with ram_en and ram_we low.
- R2: In flat mode a read of 0x0000-0x7FFF drives rom_addr equal to the CPU address, zero-extended.
- R3: In flat mode any write to 0x0000-0x1FFF switches to banking mode without enabling RAM; only reset restores flat mode.
- R4: In banking mode a write to 0x0000-0x1FFF enables RAM when data bits [3:0] equal 0xA and disables it for any other value.
- R5: In flat mode a write to 0x2000-0x3FFF sets base = (data & 0x3F) mod (ROM_BANKS - 2).
- R6: In banking mode a write to 0x2000-0x3FFF sets the offset bank to data, or to ROM_BANKS - 3 - base when data + base exceeds ROM_BANKS - 3; base is not changed in banking mode.
- R7: In banking mode a write to 0x4000-0x5FFF sets RAM bank = data mod RAM_BANKS; in flat mode that write changes nothing.
- R8: In banking mode a read of 0x0000-0x3FFF addresses bank 2 + base and a read of 0x4000-0x7FFF addresses bank 2 + base + offset, with rom_addr = bank * 0x4000 + addr[13:0].
- R9: A read or write of 0xA000-0xBFFF raises ram_en only while RAM is enabled, with ram_addr = RAM bank * 0x2000 + addr[12:0]; a write also raises ram_we and presents its data on ram_wdata.
- R10: A read of any address the mapper does not serve (0x8000-0x9FFF, 0xC000-0xFFFF, or RAM while disabled) returns 0xFF on cpu_rdata.
- R11: Outputs are registered and describe the request of the previous clock; with no read pending, cpu_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| rom_rdata | input | 8 | Data from ROM at rom_addr |
| ram_rdata | input | 8 | Data from external RAM at ram_addr |
| rom_addr | output | log2(ROM_BANKS)+14 | Physical ROM byte address |
| ram_addr | output | log2(RAM_BANKS)+13 | Physical RAM byte address |
| ram_en | output | 1 | External RAM access enable |
| ram_we | output | 1 | External RAM write enable |
| ram_wdata | output | 8 | External RAM write data |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The assertions check several rules on every cycle. The mode latch never leaves banking mode outside reset. The base stays frozen and inside its range once banking starts. Every offset written in banking mode respects the clamp. Flat-mode writes leave the RAM bank and the RAM enable untouched. RAM strobes never fire while RAM is disabled. Flat reads map one to one, and reads of unserved ranges return 0xFF. Only the bench scenarios can show that the exact physical bank arithmetic is right: the modulo on the base, the clamp value at and just past its boundary, and the effect of base and offset on both windows. The bench also shows the ordering effects: a flat-mode RAM-bank write that is lost, and a first mode write that does not enable RAM.

// File: rtl/mmc_mapper_pkg.sv
package mmc_mapper_pkg;

  // Source that serves the read data of the registered access
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } src_e;

  // 8 KB regions of the CPU space, decoded from addr[15:13]
  typedef enum logic [2:0] {
    RG_MODE  = 3'd0,  // 0x0000-0x1FFF: mode switch / RAM enable
    RG_BANK  = 3'd1,  // 0x2000-0x3FFF: base or offset select
    RG_RSEL  = 3'd2,  // 0x4000-0x5FFF: RAM bank select
    RG_ROMHI = 3'd3,  // 0x6000-0x7FFF
    RG_VID   = 3'd4,  // 0x8000-0x9FFF: not served
    RG_XRAM  = 3'd5,  // 0xA000-0xBFFF: external RAM window
    RG_WRK   = 3'd6,  // not served
    RG_TOP   = 3'd7   // not served
  } region_e;

  function automatic region_e region_of(input logic [15:0] a);
    return region_e'(a[15:13]);
  endfunction

endpackage

// File: rtl/mmc_mode_regs.sv
module mmc_mode_regs
  import mmc_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  localparam int BW = $clog2(ROM_BANKS),
  localparam int MW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [15:0]   wr_addr,
  input  logic [7:0]    wr_data,
  output logic          banking_o,
  output logic [BW-1:0] base_o,
  output logic [BW-1:0] offset_o,
  output logic [MW-1:0] ram_bank_o,
  output logic          ram_on_o
);

  localparam logic [31:0] SPAN  = 32'(ROM_BANKS - 2);
  localparam logic [31:0] LIMIT = 32'(ROM_BANKS - 3);
  localparam logic [31:0] RAMN  = 32'(RAM_BANKS);

  logic          banking_q;
  logic [BW-1:0] base_q;
  logic [BW-1:0] off_q;
  logic [MW-1:0] rb_q;
  logic          ram_on_q;
  region_e       wr_rg;

  assign wr_rg = region_of(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      banking_q <= 1'b0;
      base_q    <= '0;
      off_q     <= BW'(1);
      rb_q      <= '0;
      ram_on_q  <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_rg)
        RG_MODE: begin
          if (!banking_q) banking_q <= 1'b1;
          else            ram_on_q  <= (wr_data[3:0] == 4'hA);
        end
        RG_BANK: begin
          if (!banking_q)
            base_q <= BW'({26'd0, wr_data[5:0]} % SPAN);
          else if ((32'(wr_data) + 32'(base_q)) > LIMIT)
            off_q <= BW'(LIMIT - 32'(base_q));
          else
            off_q <= BW'(wr_data);
        end
        RG_RSEL: begin
          if (banking_q) rb_q <= MW'(32'(wr_data) % RAMN);
        end
        default: ;
      endcase
    end
  end

  assign banking_o  = banking_q;
  assign base_o     = base_q;
  assign offset_o   = off_q;
  assign ram_bank_o = rb_q;
  assign ram_on_o   = ram_on_q;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (rst)
    banking_q |=> banking_q); // R3

  AST_RAM_OFF_FLAT: assert property (@(posedge clk) disable iff (rst)
    !banking_q |-> !ram_on_q); // R4

  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(base_q) < SPAN); // R5

  AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    banking_q |=> $stable(base_q)); // R6

  AST_OFFSET_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_rg == RG_BANK && banking_q) |=> (32'(base_q) + 32'(off_q) <= LIMIT)); // R6

  AST_RSEL_FLAT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !banking_q) |=> $stable(rb_q)); // R7

endmodule

// File: rtl/mmc_xlate.sv
module mmc_xlate
  import mmc_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  localparam int BW = $clog2(ROM_BANKS),
  localparam int MW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int ROM_AW = BW + 14,
  localparam int RAM_AW = MW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              banking,
  input  logic [BW-1:0]     base,
  input  logic [BW-1:0]     offset,
  input  logic [MW-1:0]     ram_bank,
  input  logic              ram_on,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [7:0]        ram_wdata_o,
  output logic [7:0]        cpu_rdata_o
);

  region_e           rg;
  logic              rom_hit;
  logic              ram_hit;
  logic [BW-1:0]     lo_bank;
  logic [BW-1:0]     hi_bank;
  logic [ROM_AW-1:0] rom_next;
  logic [RAM_AW-1:0] ram_next;

  logic [ROM_AW-1:0] rom_addr_q;
  logic [RAM_AW-1:0] ram_addr_q;
  logic              ram_en_q;
  logic              ram_we_q;
  logic [7:0]        ram_wdata_q;
  src_e              src_q;

  always_comb begin
    rg       = region_of(cpu_addr);
    rom_hit  = !cpu_addr[15];
    ram_hit  = (rg == RG_XRAM) && ram_on;
    lo_bank  = BW'(2) + base;
    hi_bank  = lo_bank + offset;
    if (!banking)
      rom_next = ROM_AW'(cpu_addr[14:0]);
    else
      rom_next = {(cpu_addr[14] ? hi_bank : lo_bank), cpu_addr[13:0]};
    ram_next = {ram_bank, cpu_addr[12:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr_q  <= '0;
      ram_addr_q  <= '0;
      ram_en_q    <= 1'b0;
      ram_we_q    <= 1'b0;
      ram_wdata_q <= '0;
      src_q       <= SRC_NONE;
    end else begin
      if (cpu_rd && rom_hit) rom_addr_q <= rom_next;
      if ((cpu_rd || cpu_wr) && ram_hit) ram_addr_q <= ram_next;
      if (cpu_wr && ram_hit) ram_wdata_q <= cpu_wdata;
      ram_en_q <= (cpu_rd || cpu_wr) && ram_hit;
      ram_we_q <= cpu_wr && ram_hit;
      if (!cpu_rd)      src_q <= SRC_NONE;
      else if (rom_hit) src_q <= SRC_ROM;
      else if (ram_hit) src_q <= SRC_RAM;
      else              src_q <= SRC_NONE;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ROM: cpu_rdata_o = rom_rdata;
      SRC_RAM: cpu_rdata_o = ram_rdata;
      default: cpu_rdata_o = 8'hFF;
    endcase
  end

  assign rom_addr_o  = rom_addr_q;
  assign ram_addr_o  = ram_addr_q;
  assign ram_en_o    = ram_en_q;
  assign ram_we_o    = ram_we_q;
  assign ram_wdata_o = ram_wdata_q;

  AST_FLAT_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && !banking && !cpu_addr[15]) |=>
      (rom_addr_o == ROM_AW'($past(cpu_addr[14:0])))); // R2

  AST_RAM_GATED: assert property (@(posedge clk) disable iff (rst)
    ((cpu_rd || cpu_wr) && !ram_on) |=> !ram_en_o); // R9

  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> ram_en_o); // R9

  AST_UNSERVED_FF: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr[15:13] == 3'b100) |=> (cpu_rdata_o == 8'hFF)); // R10

  AST_IDLE_FF: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd) |=> (cpu_rdata_o == 8'hFF)); // R11

endmodule

// File: rtl/mmc_multicart_mapper.sv
module mmc_multicart_mapper #(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  localparam int BW = $clog2(ROM_BANKS),
  localparam int MW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
  localparam int ROM_AW = BW + 14,
  localparam int RAM_AW = MW + 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_en,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  output logic [7:0]        cpu_rdata
);

  logic          banking;
  logic [BW-1:0] base;
  logic [BW-1:0] offset;
  logic [MW-1:0] ram_bank;
  logic          ram_on;

  mmc_mode_regs #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cpu_wr),
    .wr_addr    (cpu_addr),
    .wr_data    (cpu_wdata),
    .banking_o  (banking),
    .base_o     (base),
    .offset_o   (offset),
    .ram_bank_o (ram_bank),
    .ram_on_o   (ram_on)
  );

  mmc_xlate #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS)
  ) u_xlate (
    .clk         (clk),
    .rst         (rst),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .banking     (banking),
    .base        (base),
    .offset      (offset),
    .ram_bank    (ram_bank),
    .ram_on      (ram_on),
    .rom_rdata   (rom_rdata),
    .ram_rdata   (ram_rdata),
    .rom_addr_o  (rom_addr),
    .ram_addr_o  (ram_addr),
    .ram_en_o    (ram_en),
    .ram_we_o    (ram_we),
    .ram_wdata_o (ram_wdata),
    .cpu_rdata_o (cpu_rdata)
  );

endmodule

// File: tb/mmc_multicart_mapper_bench.sv
module mmc_multicart_mapper_bench;

  localparam int ROM_AW = 20;  // 64 ROM banks
  localparam int RAM_AW = 15;  // 4 RAM banks
  localparam int N = 31;
  // entry: {kind[1:0], addr[15:0], data[7:0], expected address[19:0], req[3:0]}
  // kind 0 = write, 1 = ROM read, 2 = read expecting 0xFF, 3 = RAM read
  localparam logic [49:0] TBL [N] = '{
    {2'd1, 16'h0123, 8'h00, 20'h00123, 4'd2},   // R2 flat
    {2'd1, 16'h4567, 8'h00, 20'h04567, 4'd2},   // R2
    {2'd0, 16'h4000, 8'h03, 20'h00000, 4'd7},   // R7 flat RAM-bank write lost
    {2'd0, 16'h2000, 8'h45, 20'h00000, 4'd5},   // R5 base = 5
    {2'd1, 16'h7FFF, 8'h00, 20'h07FFF, 4'd2},   // R2 flat after base set
    {2'd2, 16'hA000, 8'h00, 20'h00000, 4'd9},   // R9 RAM off
    {2'd2, 16'h8000, 8'h00, 20'h00000, 4'd10},  // R10
    {2'd2, 16'hFF00, 8'h00, 20'h00000, 4'd10},  // R10
    {2'd0, 16'h0000, 8'h0A, 20'h00000, 4'd3},   // R3 enter banking
    {2'd2, 16'hA010, 8'h00, 20'h00000, 4'd3},   // R3 RAM still off
    {2'd1, 16'h0123, 8'h00, 20'h1C123, 4'd8},   // R8 bank 7
    {2'd1, 16'h4010, 8'h00, 20'h20010, 4'd8},   // R8 bank 8
    {2'd0, 16'h2000, 8'h40, 20'h00000, 4'd6},   // R6 clamp to 56
    {2'd1, 16'h4000, 8'h00, 20'hFC000, 4'd6},   // R6 bank 63
    {2'd0, 16'h2000, 8'h10, 20'h00000, 4'd6},
    {2'd1, 16'h4ABC, 8'h00, 20'h5CABC, 4'd8},   // R8 bank 23
    {2'd0, 16'h2000, 8'h38, 20'h00000, 4'd6},   // R6 exactly at limit
    {2'd1, 16'h7001, 8'h00, 20'hFF001, 4'd6},
    {2'd0, 16'h2000, 8'h39, 20'h00000, 4'd6},   // R6 one past limit
    {2'd1, 16'h7001, 8'h00, 20'hFF001, 4'd6},
    {2'd1, 16'h2123, 8'h00, 20'h1E123, 4'd6},   // R6 base unchanged
    {2'd0, 16'h0000, 8'h1A, 20'h00000, 4'd4},   // R4 RAM on
    {2'd3, 16'hA010, 8'h00, 20'h00010, 4'd7},   // R7 bank still 0
    {2'd0, 16'h4000, 8'h06, 20'h00000, 4'd7},   // R7 6 mod 4 = 2
    {2'd3, 16'hBFFF, 8'h00, 20'h05FFF, 4'd7},
    {2'd0, 16'h0000, 8'h0B, 20'h00000, 4'd4},   // R4 RAM off
    {2'd2, 16'hA000, 8'h00, 20'h00000, 4'd4},
    {2'd0, 16'h0000, 8'hFA, 20'h00000, 4'd4},   // R4 on again, still banking
    {2'd3, 16'hA001, 8'h00, 20'h04001, 4'd4},
    {2'd0, 16'h4000, 8'h07, 20'h00000, 4'd7},   // R7 bank 3
    {2'd3, 16'hB000, 8'h00, 20'h07000, 4'd9}    // R9
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_rd = 1'b0;
  logic              cpu_wr = 1'b0;
  logic [7:0]        rom_rdata;
  logic [7:0]        ram_rdata;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_en;
  logic              ram_we;
  logic [7:0]        ram_wdata;
  logic [7:0]        cpu_rdata;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] romv(input logic [19:0] a);
    return a[7:0] ^ {2'b00, a[19:14]};
  endfunction

  function automatic logic [7:0] ramv(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  assign rom_rdata = romv(rom_addr);
  assign ram_rdata = ramv(ram_addr);

  mmc_multicart_mapper #(.ROM_BANKS(64), .RAM_BANKS(4)) u_mmc_multicart_mapper (
    .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_rd (cpu_rd), .cpu_wr (cpu_wr), .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata), .rom_addr (rom_addr), .ram_addr (ram_addr),
    .ram_en (ram_en), .ram_we (ram_we), .ram_wdata (ram_wdata),
    .cpu_rdata (cpu_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input bit w, input bit r, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  logic [49:0] e;
  string       tag;

  initial begin
    do_reset();
    // R1 reset outputs
    chk("R1 rdata", 32'(cpu_rdata), 32'hFF);
    chk("R1 ram_en", 32'(ram_en), 32'd0);
    chk("R1 ram_we", 32'(ram_we), 32'd0);

    for (int i = 0; i < N; i++) begin
      e = TBL[i];
      tag = $sformatf("R%0d entry %0d", e[3:0], i);
      op(e[49:48] == 2'd0, e[49:48] != 2'd0, e[47:32], e[31:24]);
      case (e[49:48])
        2'd1: begin
          chk(tag, 32'(rom_addr), 32'(e[23:4]));
          chk(tag, 32'(cpu_rdata), 32'(romv(e[23:4])));
        end
        2'd2: begin
          chk(tag, 32'(cpu_rdata), 32'hFF);
          chk(tag, 32'(ram_en), 32'd0);
        end
        2'd3: begin
          chk(tag, 32'(ram_en), 32'd1);
          chk(tag, 32'(ram_we), 32'd0);
          chk(tag, 32'(ram_addr), 32'(e[18:4]));
          chk(tag, 32'(cpu_rdata), 32'(ramv(e[18:4])));
        end
        default: ;
      endcase
    end

    // R9 RAM write while enabled, RAM bank 3
    op(1'b1, 1'b0, 16'hA123, 8'h77);
    chk("R9 we", 32'(ram_we), 32'd1);
    chk("R9 en", 32'(ram_en), 32'd1);
    chk("R9 waddr", 32'(ram_addr), 32'h6123);
    chk("R9 wdata", 32'(ram_wdata), 32'h77);
    // R9 RAM write while disabled
    op(1'b1, 1'b0, 16'h0000, 8'h00);
    op(1'b1, 1'b0, 16'hA123, 8'h55);
    chk("R9 off en", 32'(ram_en), 32'd0);
    chk("R9 off we", 32'(ram_we), 32'd0);

    // R11 one-cycle latency and idle 0xFF
    op(1'b0, 1'b1, 16'h0004, 8'h00);
    chk("R11 rdata after read", 32'(cpu_rdata), 32'(romv(20'h1C004)));
    @(negedge clk);
    chk("R11 idle rdata", 32'(cpu_rdata), 32'hFF);

    // R3 reset returns to flat mode; R1 offset 1 and RAM off after mode switch
    do_reset();
    op(1'b0, 1'b1, 16'h4567, 8'h00);
    chk("R3 flat after reset", 32'(rom_addr), 32'h04567);
    op(1'b1, 1'b0, 16'h0000, 8'h0A);
    op(1'b0, 1'b1, 16'h4000, 8'h00);
    chk("R1 offset 1 base 0", 32'(rom_addr), 32'h0C000);
    op(1'b0, 1'b1, 16'hA000, 8'h00);
    chk("R1 RAM disabled", 32'(cpu_rdata), 32'hFF);

    // R5 modulo wrap: 0x3F -> 63 mod 62 = 1, lower window bank 3
    do_reset();
    op(1'b1, 1'b0, 16'h2000, 8'hFF);
    op(1'b1, 1'b0, 16'h1FFF, 8'h00);
    op(1'b0, 1'b1, 16'h0000, 8'h00);
    chk("R5 base wrap", 32'(rom_addr), 32'h0C000);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule